// File: doc/BRIEF.md
# Fractional-N Divider Ratio Controller

This block chooses, once per reference period, the modulus that a dual-modulus feedback divider uses next. It is programmed with an integer part N, a numerator k and a denominator m. Across any run of m reference strobes the chosen moduli add up to N·m + k, so the average ratio is N + k/m. A phase-accumulator carry marks the periods that divide by N+1 rather than N.

Two orders are available. The first-order mode uses a single accumulator and gives a strictly periodic N/N+1 pattern. The second-order mode cascades two accumulators and adds a differenced second carry. This dithers the pattern over N-1 … N+2 and pushes the periodic error toward high offsets. Settings are sampled only on a strobe. The numerator may be retuned every period, for example by a spread-spectrum sweep, without resetting the accumulators. A change of denominator or order restarts the sequence from a zeroed state.

Top module: `frac_ratio_ctrl`

## Requirements
- R1: After reset, and until the first strobe, `divOut` is 0 and `carryOut` is 0.
- R2: Both outputs change only on a clock edge at which `refStrobe` is 1, and they hold their values between strobes.
- R3: First-order mode (`orderSel` = 0): each strobe adds k to an accumulator modulo m. The strobe that wraps it sets `carryOut` = 1 and `divOut` = N+1; any other strobe gives `carryOut` = 0 and `divOut` = N. The result appears on the edge of that strobe.
- R4: First-order mode: over any m consecutive strobes with fixed settings, `carryOut` is 1 exactly k times, and the `divOut` values sum to N·m + k. The accumulator stays below m.
- R5: When k is 0, every strobe gives `divOut` = N and `carryOut` = 0.
- R6: A change of k alone keeps the accumulator contents. A strobe that carries a different m or a different order than the previous strobe first zeroes all accumulator state and then applies the step.
- R7: A numerator k ≥ m is treated as m-1. A denominator of 0 is treated as 1.
- R8: An integer part below 2 is treated as 2.
- R9: A strobe with `enable` = 0 gives `divOut` = N and `carryOut` = 0 and zeroes all accumulator state.
- R10: Second-order mode (`orderSel` = 1): `divOut` = N + c1 + c2 − c2prev, where c1 is the first-stage carry and c2 is the carry of a second accumulator that sums the first stage's residue. `divOut` stays within N-1 … N+2, and `carryOut` is c1.
- R11: Second-order mode, starting from a zeroed state: the sum of `divOut` over the first j·m strobes is N·j·m + j·k or one more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | 0: integer divide, state held at zero |
| refStrobe | input | 1 | One pulse per reference period; advances the sequence |
| intDiv | input | INT_W | Integer part N |
| fracNum | input | FRAC_W | Fraction numerator k |
| fracMod | input | FRAC_W | Fraction denominator m |
| orderSel | input | 1 | 0 first order, 1 second order |
| divOut | output | INT_W+1 | Divide value for the coming period |
| carryOut | output | 1 | First-stage accumulator wrap |

## Verification
A corrupted accumulator shows up at the ports on the very next strobe. There the carry fires at the wrong point, so `divOut` departs from the per-strobe model at once. Over a window of m strobes it also breaks the N·m + k sum. A second-stage error or a wrong remembered carry shows as a value outside N-1 … N+2 or as a window sum off by more than one. A missed clear on a change of m or order is caught by sequences built so that the stale and the cleared accumulator give different carries on the first strobe after the change.

// File: rtl/frac_ratio_pkg.sv
package frac_ratio_pkg;

  // Strobes sent from the configuration control to the accumulator datapath.
  typedef struct packed {
    logic step;    // advance the sequence on this edge
    logic clear;   // start from zeroed accumulator state before the step
    logic bypass;  // integer-only divide, state forced to zero
  } ctlStrobe_t;

endpackage

// File: rtl/frac_ratio_cfg.sv
module frac_ratio_cfg
  import frac_ratio_pkg::*;
#(
  parameter int INT_W           = 8,
  parameter int FRAC_W          = 8,
  parameter int N_MIN           = 2,
  parameter bit SECOND_ORDER_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              refStrobe,
  input  logic [INT_W-1:0]  intDiv,
  input  logic [FRAC_W-1:0] fracNum,
  input  logic [FRAC_W-1:0] fracMod,
  input  logic              orderSel,
  output ctlStrobe_t        ctl,
  output logic [INT_W-1:0]  nEff,
  output logic [FRAC_W-1:0] kEff,
  output logic [FRAC_W-1:0] mEff,
  output logic              orderEff
);

  localparam logic [INT_W-1:0]  N_FLOOR = INT_W'(N_MIN);
  localparam logic [FRAC_W-1:0] ONE_F   = FRAC_W'(1);

  logic [FRAC_W-1:0] mPrev;
  logic              orderPrev;
  logic              modeChange;

  // Legalise the programmed setting as it is sampled.
  always_comb begin
    mEff     = (fracMod == '0) ? ONE_F : fracMod;
    kEff     = (fracNum >= mEff) ? (mEff - ONE_F) : fracNum;
    nEff     = (intDiv < N_FLOOR) ? N_FLOOR : intDiv;
    orderEff = SECOND_ORDER_EN ? orderSel : 1'b0;
  end

  // A new denominator or order invalidates the accumulator contents.
  always_comb begin
    modeChange = (mEff != mPrev) || (orderEff != orderPrev);
    ctl.step   = refStrobe;
    ctl.bypass = ~enable;
    ctl.clear  = refStrobe & (modeChange | ~enable);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mPrev     <= '0;
      orderPrev <= 1'b0;
    end else if (refStrobe) begin
      mPrev     <= mEff;
      orderPrev <= orderEff;
    end
  end

endmodule

// File: rtl/frac_ratio_accum.sv
module frac_ratio_accum
  import frac_ratio_pkg::*;
#(
  parameter int INT_W           = 8,
  parameter int FRAC_W          = 8,
  parameter int DIV_W           = INT_W + 1,
  parameter bit SECOND_ORDER_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobe_t        ctl,
  input  logic [INT_W-1:0]  nEff,
  input  logic [FRAC_W-1:0] kEff,
  input  logic [FRAC_W-1:0] mEff,
  input  logic              orderEff,
  output logic [DIV_W-1:0]  divOut,
  output logic              carryOut
);

  localparam int SUM_W = FRAC_W + 1;

  logic [FRAC_W-1:0] acc1Q, acc2Q;
  logic              c2PrevQ;

  logic [FRAC_W-1:0] acc1Base, acc1Nxt, acc2Nxt;
  logic [SUM_W-1:0]  sum1, mWide;
  logic              c1, c2, c2pUsed;
  logic [DIV_W-1:0]  nWide, divNxt;

  // Stage one: residue accumulator, carry selects the extra count.
  always_comb begin
    mWide    = {1'b0, mEff};
    acc1Base = ctl.clear ? '0 : acc1Q;
    sum1     = {1'b0, acc1Base} + {1'b0, kEff};
    c1       = (sum1 >= mWide);
    acc1Nxt  = FRAC_W'(c1 ? (sum1 - mWide) : sum1);
  end

  // Stage two: present only when the noise-shaping variant is built.
  generate
    if (SECOND_ORDER_EN) begin : g_stage2
      logic [FRAC_W-1:0] acc2Base;
      logic [SUM_W-1:0]  sum2;
      logic              zeroS2;
      always_comb begin
        zeroS2   = ctl.clear | ~orderEff;
        acc2Base = zeroS2 ? '0 : acc2Q;
        c2pUsed  = zeroS2 ? 1'b0 : c2PrevQ;
        sum2     = {1'b0, acc2Base} + {1'b0, acc1Nxt};
        c2       = orderEff & (sum2 >= mWide);
        acc2Nxt  = orderEff ? FRAC_W'(c2 ? (sum2 - mWide) : sum2) : '0;
      end
    end else begin : g_stage1Only
      assign c2      = 1'b0;
      assign c2pUsed = 1'b0;
      assign acc2Nxt = '0;
    end
  endgenerate

  // Divide value: N plus first carry plus differenced second carry.
  always_comb begin
    nWide  = DIV_W'(nEff);
    divNxt = nWide + DIV_W'(c1) + DIV_W'(c2) - DIV_W'(c2pUsed);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc1Q    <= '0;
      acc2Q    <= '0;
      c2PrevQ  <= 1'b0;
      divOut   <= '0;
      carryOut <= 1'b0;
    end else if (ctl.step) begin
      if (ctl.bypass) begin
        acc1Q    <= '0;
        acc2Q    <= '0;
        c2PrevQ  <= 1'b0;
        divOut   <= nWide;
        carryOut <= 1'b0;
      end else begin
        acc1Q    <= acc1Nxt;
        acc2Q    <= acc2Nxt;
        c2PrevQ  <= c2;
        divOut   <= divNxt;
        carryOut <= c1;
      end
    end
  end

  // Settings in force for the present outputs, kept for the checks below.
  logic [DIV_W-1:0]  nUsed;
  logic [FRAC_W-1:0] mUsed;
  logic              orderUsed, started;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nUsed     <= DIV_W'(2);
      mUsed     <= FRAC_W'(1);
      orderUsed <= 1'b0;
      started   <= 1'b0;
    end else if (ctl.step) begin
      nUsed     <= nWide;
      mUsed     <= ctl.bypass ? FRAC_W'(1) : mEff;
      orderUsed <= ctl.bypass ? 1'b0 : orderEff;
      started   <= 1'b1;
    end
  end

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.step |=> ($stable(divOut) && $stable(carryOut)));

  // R3
  carry_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !orderUsed && carryOut) |-> (divOut == nUsed + DIV_W'(1)));

  // R4
  acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc1Q < mUsed);

  // R5
  integer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.step && !ctl.bypass && ctl.clear && kEff == '0) |=> !carryOut);

  // R9
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.step && ctl.bypass) |=> (!carryOut && divOut == $past(DIV_W'(nEff))));

  // R10
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> ((divOut + DIV_W'(1)) >= nUsed && divOut <= nUsed + DIV_W'(2)));

endmodule

// File: rtl/frac_ratio_ctrl.sv
module frac_ratio_ctrl
  import frac_ratio_pkg::*;
#(
  parameter int INT_W           = 8,
  parameter int FRAC_W          = 8,
  parameter bit SECOND_ORDER_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              refStrobe,
  input  logic [INT_W-1:0]  intDiv,
  input  logic [FRAC_W-1:0] fracNum,
  input  logic [FRAC_W-1:0] fracMod,
  input  logic              orderSel,
  output logic [INT_W:0]    divOut,
  output logic              carryOut
);

  localparam int DIV_W = INT_W + 1;

  ctlStrobe_t        ctl;
  logic [INT_W-1:0]  nEff;
  logic [FRAC_W-1:0] kEff, mEff;
  logic              orderEff;

  frac_ratio_cfg #(
    .INT_W(INT_W), .FRAC_W(FRAC_W), .N_MIN(2), .SECOND_ORDER_EN(SECOND_ORDER_EN)
  ) cfg_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .refStrobe(refStrobe),
    .intDiv(intDiv), .fracNum(fracNum), .fracMod(fracMod), .orderSel(orderSel),
    .ctl(ctl), .nEff(nEff), .kEff(kEff), .mEff(mEff), .orderEff(orderEff)
  );

  frac_ratio_accum #(
    .INT_W(INT_W), .FRAC_W(FRAC_W), .DIV_W(DIV_W), .SECOND_ORDER_EN(SECOND_ORDER_EN)
  ) accum_i (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .nEff(nEff), .kEff(kEff),
    .mEff(mEff), .orderEff(orderEff), .divOut(divOut), .carryOut(carryOut)
  );

endmodule

// File: tb/frac_ratio_ctrl_tb_top.sv
module frac_ratio_ctrl_tb_top;
  localparam int INT_W  = 8;
  localparam int FRAC_W = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, enable, refStrobe, orderSel;
  logic [INT_W-1:0]  intDiv;
  logic [FRAC_W-1:0] fracNum, fracMod;
  logic [INT_W:0]    divOut;
  logic              carryOut;

  frac_ratio_ctrl #(.INT_W(INT_W), .FRAC_W(FRAC_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .refStrobe(refStrobe),
    .intDiv(intDiv), .fracNum(fracNum), .fracMod(fracMod), .orderSel(orderSel),
    .divOut(divOut), .carryOut(carryOut)
  );

  int checks = 0;
  int fails  = 0;
  string curReq = "R1";

  // Behavioural reference, advanced on every strobe edge.
  int mdA1, mdA2, mdC2p, mdPm, mdPo, expDiv, expCarry;
  int mm, mk, mn, mo, mc1, mc2;

  always @(posedge clk) begin
    if (!rst_n) begin
      mdA1 = 0; mdA2 = 0; mdC2p = 0; mdPm = 0; mdPo = 0; expDiv = 0; expCarry = 0;
    end else if (refStrobe) begin
      mm = (fracMod == 0) ? 1 : int'(fracMod);
      mk = (int'(fracNum) >= mm) ? mm - 1 : int'(fracNum);
      mn = (intDiv < 2) ? 2 : int'(intDiv);
      mo = int'(orderSel);
      if (!enable) begin
        mdA1 = 0; mdA2 = 0; mdC2p = 0; expDiv = mn; expCarry = 0;
      end else begin
        if (mm != mdPm || mo != mdPo) begin mdA1 = 0; mdA2 = 0; mdC2p = 0; end
        mdA1 = mdA1 + mk;
        mc1 = (mdA1 >= mm) ? 1 : 0;
        if (mc1 == 1) mdA1 = mdA1 - mm;
        if (mo == 1) begin
          mdA2 = mdA2 + mdA1;
          mc2 = (mdA2 >= mm) ? 1 : 0;
          if (mc2 == 1) mdA2 = mdA2 - mm;
          expDiv = mn + mc1 + mc2 - mdC2p;
          mdC2p = mc2;
        end else begin
          expDiv = mn + mc1;
        end
        expCarry = mc1;
      end
      mdPm = mm; mdPo = mo;
    end
  end

  // Per-cycle comparison against the reference.
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (int'(divOut) != expDiv || int'(carryOut) != expCarry) begin
        fails++;
        $display("FAIL %s model: div actual %0d expected %0d, carry actual %0d expected %0d",
                 curReq, divOut, expDiv, carryOut, expCarry);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setCfg(input int n, input int k, input int m, input int o);
    intDiv = INT_W'(n); fracNum = FRAC_W'(k); fracMod = FRAC_W'(m); orderSel = o[0];
  endtask

  // One strobe; result read on the next falling edge; then gap idle cycles.
  task automatic stepOnce(output int d, output int c, input int gap);
    refStrobe = 1'b1;
    @(negedge clk);
    d = int'(divOut); c = int'(carryOut);
    refStrobe = 1'b0;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      chk(int'(divOut) == d && int'(carryOut) == c, "R2 hold", int'(divOut), d);
    end
  endtask

  task automatic runWindow(input int len, input int gap, output int carries,
                           output int sum, output int lo, output int hi);
    int d, c;
    carries = 0; sum = 0; lo = 1 << 20; hi = -1;
    for (int i = 0; i < len; i++) begin
      stepOnce(d, c, gap);
      carries += c; sum += d;
      if (d < lo) lo = d;
      if (d > hi) hi = d;
    end
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired: actual 0 expected 1 completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int d, c, cr, sm, lo, hi, tot;
    rst_n = 1'b0; enable = 1'b1; refStrobe = 1'b0;
    setCfg(10, 3, 8, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    curReq = "R1";
    chk(divOut == 0, "R1 reset div", int'(divOut), 0);
    chk(carryOut == 0, "R1 reset carry", int'(carryOut), 0);
    repeat (3) @(negedge clk);
    chk(divOut == 0 && carryOut == 0, "R1 idle before strobe", int'(divOut), 0);

    // R3: k=3, m=8 from zero: residues 3,6,1 -> carry on the third strobe.
    curReq = "R3";
    stepOnce(d, c, 0); chk(d == 10 && c == 0, "R3 step1", d, 10);
    stepOnce(d, c, 0); chk(d == 10 && c == 0, "R3 step2", d, 10);
    stepOnce(d, c, 0); chk(d == 11 && c == 1, "R3 step3", d, 11);

    // R4: any window of m strobes.
    curReq = "R4";
    runWindow(8, 0, cr, sm, lo, hi);
    chk(cr == 3, "R4 carries", cr, 3);
    chk(sm == 83, "R4 sum", sm, 83);
    curReq = "R2";
    runWindow(8, 2, cr, sm, lo, hi);
    chk(sm == 83, "R4 sum with gaps R2", sm, 83);

    // R5: integer mode.
    curReq = "R5";
    setCfg(12, 0, 7, 0);
    runWindow(16, 0, cr, sm, lo, hi);
    chk(cr == 0, "R5 no carries", cr, 0);
    chk(sm == 12 * 16, "R5 sum", sm, 192);

    // R6: k change keeps state, m change clears it.
    curReq = "R6";
    setCfg(20, 3, 10, 0);
    runWindow(3, 0, cr, sm, lo, hi);          // residue 9
    chk(cr == 0, "R6 preamble carries", cr, 0);
    setCfg(20, 5, 10, 0);
    stepOnce(d, c, 0); chk(c == 1 && d == 21, "R6 k change keeps residue", c, 1);
    stepOnce(d, c, 0); chk(c == 0, "R6 residue 9", c, 0);
    setCfg(20, 5, 12, 0);
    stepOnce(d, c, 0); chk(c == 0 && d == 20, "R6 m change clears", c, 0);

    // R7: clamping of k and m.
    curReq = "R7";
    setCfg(30, 9, 4, 0);
    runWindow(4, 0, cr, sm, lo, hi);
    chk(cr == 3, "R7 k clamped carries", cr, 3);
    chk(sm == 123, "R7 k clamped sum", sm, 123);
    setCfg(30, 5, 0, 0);
    runWindow(5, 0, cr, sm, lo, hi);
    chk(cr == 0 && sm == 150, "R7 m zero as one", sm, 150);

    // R8: integer floor.
    curReq = "R8";
    setCfg(1, 0, 5, 0);
    stepOnce(d, c, 0); chk(d == 2, "R8 N=1", d, 2);
    setCfg(0, 0, 5, 0);
    stepOnce(d, c, 1); chk(d == 2, "R8 N=0", d, 2);

    // R9: disable forces N and clears state.
    curReq = "R9";
    setCfg(10, 3, 8, 0);
    runWindow(2, 0, cr, sm, lo, hi);          // residue 6 (fresh after m change)
    enable = 1'b0;
    stepOnce(d, c, 0); chk(d == 10 && c == 0, "R9 disabled", d, 10);
    enable = 1'b1;
    stepOnce(d, c, 0); chk(c == 0, "R9 state cleared", c, 0);
    runWindow(8, 0, cr, sm, lo, hi);
    chk(cr == 3 && sm == 83, "R9 window after re-enable", sm, 83);

    // R10/R11: second order.
    curReq = "R10";
    setCfg(16, 5, 13, 1);
    runWindow(13, 0, cr, sm, lo, hi);
    chk(cr == 5, "R10 first-stage carries", cr, 5);
    chk(lo >= 15 && hi <= 18, "R10 range", hi, 18);
    curReq = "R11";
    chk(sm == 213 || sm == 214, "R11 one window", sm, 213);
    tot = sm;
    runWindow(26, 1, cr, sm, lo, hi);
    tot += sm;
    chk(tot == 16 * 39 + 15 || tot == 16 * 39 + 16, "R11 three windows", tot, 639);
    chk(lo >= 15 && hi <= 18, "R10 range with gaps", lo, 15);

    curReq = "R10";
    setCfg(255, 1, 2, 1);
    runWindow(8, 0, cr, sm, lo, hi);
    chk(lo >= 254 && hi <= 257, "R10 top of range", hi, 257);
    chk(sm == 255 * 8 + 4 || sm == 255 * 8 + 5, "R11 large N sum", sm, 2044);

    @(negedge clk);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule